// File: doc/BRIEF.md
# Termination Enable Sequencer

This block lives on the device side of a DDR2-style memory. It decides each clock whether on-die termination is active on the data, strobe and mask pins, and which of three resistor legs is switched in. It keeps its own copy of the two termination-select bits. It updates that copy whenever the decoded extended mode register write strobe fires.

The external termination control pin is not passed straight through. It is qualified by the current power state and blocked for a fixed holdoff after any mode-register write that enables termination. A pin high at a forbidden time is dropped and raises a one-cycle violation flag. Self refresh and holdoff windows are the two main cases. Reserved select codes are also flagged.

All outputs are registered. An input sampled at one rising edge shows at the outputs right after that edge.

Top module: `term_seq`

## Requirements
- R1: A synchronous active-low reset clears the stored select, the holdoff counter and all three outputs. After reset, termination stays off until a new enabling write arrives.
- R2: The stored select {E6,E2} = 01 drives leg_sel = 3'b001 (75 ohm leg). The value 10 drives 3'b010 (150 ohm leg). The value 11 drives 3'b100 (50 ohm leg) when EN_50 = 1. The value 00 disables termination.
- R3: term_on rises only when term_ctl is high, the stored select is enabled, and pwr_mode is active (1), active power-down fast exit (2), active power-down slow exit (3) or precharge power-down (4). Each output reflects the inputs sampled at the previous rising edge.
- R4: term_ctl high while pwr_mode is self refresh (5) keeps termination off and sets term_viol on the next cycle.
- R5: From reset through initialization (pwr_mode 0), before any enabling write, term_ctl has no effect on term_on or leg_sel.
- R6: After a write that enables termination, term_ctl high in the write cycle or in any of the HOLD_CYC (default 8) cycles that follow is ignored and sets term_viol.
- R7: Every further enabling write restarts the full HOLD_CYC window.
- R8: With EN_50 = 0, the code 11 is reserved. Writing it sets term_viol on the next cycle and stores a disabled select, so a later term_ctl high leaves termination off.
- R9: leg_sel has exactly one bit set while term_on is high, and is zero while term_on is low.
- R10: A write of 00 turns termination off from the write cycle on and starts no holdoff, so a term_ctl high after it raises no violation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| emr_wr | input | 1 | Decoded extended mode register write strobe |
| emr_sel | input | 2 | Termination-select bits {E6,E2} of the write |
| term_ctl | input | 1 | External termination control pin |
| pwr_mode | input | 3 | Operating mode: 0 init, 1 active, 2 APD fast, 3 APD slow, 4 PPD, 5 self refresh |
| term_on | output | 1 | Termination active |
| leg_sel | output | 3 | One-hot resistor leg select |
| term_viol | output | 1 | Protocol-violation pulse |

## Verification
A stale or wrong stored select shows one cycle after the next legal term_ctl high: either a wrong leg_sel bit or no termination at all. A holdoff counter that is loaded, restarted or drained wrongly moves the first cycle in which term_ctl takes effect. That edge is therefore probed exactly at the last blocked cycle and the first free cycle, including after a restart part-way through a window. A power-state qualifier error shows as term_on in self refresh or init, or as a missing term_viol, on the cycle after the offending sample.

// File: rtl/term_seq_pkg.sv
package term_seq_pkg;

   localparam int LEG_W = 3;

   localparam logic [2:0] MODE_INIT     = 3'd0;
   localparam logic [2:0] MODE_ACT      = 3'd1;
   localparam logic [2:0] MODE_APD_FAST = 3'd2;
   localparam logic [2:0] MODE_APD_SLOW = 3'd3;
   localparam logic [2:0] MODE_PPD      = 3'd4;
   localparam logic [2:0] MODE_SREF     = 3'd5;

   // power states in which the control pin may switch termination
   function automatic logic mode_allows(input logic [2:0] m);
      case (m)
         MODE_ACT, MODE_APD_FAST, MODE_APD_SLOW, MODE_PPD: return 1'b1;
         MODE_INIT, MODE_SREF:                             return 1'b0;
         default:                                          return 1'b0;
      endcase
   endfunction

endpackage

// File: rtl/term_decode.sv
module term_decode
   import term_seq_pkg::*;
#(
   parameter bit EN_50 = 1'b1
) (
   input  logic [1:0]       sel,
   output logic [LEG_W-1:0] legs,
   output logic             rsv
);

   generate
      if (EN_50) begin : g_full
         always_comb begin
            rsv = 1'b0;
            case (sel)
               2'b01:   legs = 3'b001;
               2'b10:   legs = 3'b010;
               2'b11:   legs = 3'b100;
               default: legs = 3'b000;
            endcase
         end
      end else begin : g_rsv
         always_comb begin
            rsv = (sel == 2'b11);
            case (sel)
               2'b01:   legs = 3'b001;
               2'b10:   legs = 3'b010;
               default: legs = 3'b000;
            endcase
         end
      end
   endgenerate

endmodule

// File: rtl/term_holdoff.sv
module term_holdoff #(
   parameter int HOLD_CYC = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic clear,
   output logic busy
);

   localparam int CNT_W = $clog2(HOLD_CYC + 1);
   localparam logic [CNT_W-1:0] CNT_INIT = CNT_W'(HOLD_CYC);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)              cnt_q <= '0;
      else if (clear)          cnt_q <= '0;
      else if (load)           cnt_q <= CNT_INIT;
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign busy = (cnt_q != '0);

endmodule

// File: rtl/term_seq.sv
module term_seq
   import term_seq_pkg::*;
#(
   parameter int HOLD_CYC = 8,
   parameter bit EN_50    = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             emr_wr,
   input  logic [1:0]       emr_sel,
   input  logic             term_ctl,
   input  logic [2:0]       pwr_mode,
   output logic             term_on,
   output logic [LEG_W-1:0] leg_sel,
   output logic             term_viol
);

   initial begin
      assert (HOLD_CYC >= 1 && HOLD_CYC <= 4096)
         else $error("term_seq: HOLD_CYC out of range");
   end

   logic [LEG_W-1:0] new_legs;
   logic             new_rsv;
   logic             new_en;
   logic [LEG_W-1:0] legs_q;
   logic             hold_busy;
   logic             blocked;
   logic             on_d;
   logic             viol_d;

   term_decode #(.EN_50(EN_50)) u_dec (
      .sel  (emr_sel),
      .legs (new_legs),
      .rsv  (new_rsv)
   );

   assign new_en = |new_legs;

   term_holdoff #(.HOLD_CYC(HOLD_CYC)) u_hold (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (emr_wr && new_en),
      .clear (emr_wr && !new_en),
      .busy  (hold_busy)
   );

   // stored leg pattern doubles as the enable copy of the register
   always_ff @(posedge clk) begin
      if (!rst_n)      legs_q <= '0;
      else if (emr_wr) legs_q <= new_legs;
   end

   assign blocked = hold_busy || (emr_wr && new_en);

   always_comb begin
      on_d   = term_ctl && mode_allows(pwr_mode) && (|legs_q)
               && !blocked && !emr_wr;
      viol_d = (term_ctl && (pwr_mode == MODE_SREF))
               || (term_ctl && blocked)
               || (emr_wr && new_rsv);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         term_on   <= 1'b0;
         leg_sel   <= '0;
         term_viol <= 1'b0;
      end else begin
         term_on   <= on_d;
         leg_sel   <= on_d ? legs_q : '0;
         term_viol <= viol_d;
      end
   end

endmodule

// File: rtl/term_seq_chk.sv
module term_seq_chk
   import term_seq_pkg::*;
#(
   parameter int HOLD_CYC = 8,
   parameter bit EN_50    = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             emr_wr,
   input logic [1:0]       emr_sel,
   input logic             term_ctl,
   input logic [2:0]       pwr_mode,
   input logic             term_on,
   input logic [LEG_W-1:0] leg_sel,
   input logic             term_viol
);

   localparam int WIN_W = $clog2(HOLD_CYC + 1);

   logic [WIN_W-1:0] win_q;
   logic             wr_en;

   assign wr_en = emr_wr && (emr_sel != 2'b00) && (EN_50 || emr_sel != 2'b11);

   always_ff @(posedge clk) begin
      if (!rst_n)            win_q <= '0;
      else if (wr_en)        win_q <= WIN_W'(HOLD_CYC);
      else if (emr_wr)       win_q <= '0;
      else if (win_q != '0)  win_q <= win_q - 1'b1;
   end

   // R9
   leg_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      term_on |-> ($countones(leg_sel) == 1));

   // R9
   leg_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !term_on |-> (leg_sel == '0));

   // R3
   mode_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (term_ctl && !mode_allows(pwr_mode)) |=> !term_on);

   // R4
   sref_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (term_ctl && pwr_mode == MODE_SREF) |=> (term_viol && !term_on));

   // R6
   hold_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (term_ctl && (win_q != '0 || wr_en)) |=> (term_viol && !term_on));

   // R10
   off_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (emr_wr && emr_sel == 2'b00) |=> !term_on);

endmodule

bind term_seq term_seq_chk #(.HOLD_CYC(HOLD_CYC), .EN_50(EN_50)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .emr_wr    (emr_wr),
   .emr_sel   (emr_sel),
   .term_ctl  (term_ctl),
   .pwr_mode  (pwr_mode),
   .term_on   (term_on),
   .leg_sel   (leg_sel),
   .term_viol (term_viol)
);

// File: tb/term_seq_tb.sv
`timescale 1ns/1ps
module term_seq_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       emr_wr = 1'b0;
   logic [1:0] emr_sel = 2'b00;
   logic       term_ctl = 1'b0;
   logic [2:0] pwr_mode = 3'd0;
   logic       term_on, term_on_r;
   logic [2:0] leg_sel, leg_sel_r;
   logic       term_viol, term_viol_r;

   int n_chk = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   term_seq u_dut (
      .clk(clk), .rst_n(rst_n), .emr_wr(emr_wr), .emr_sel(emr_sel),
      .term_ctl(term_ctl), .pwr_mode(pwr_mode),
      .term_on(term_on), .leg_sel(leg_sel), .term_viol(term_viol)
   );

   term_seq #(.EN_50(1'b0)) u_dut_rsv (
      .clk(clk), .rst_n(rst_n), .emr_wr(emr_wr), .emr_sel(emr_sel),
      .term_ctl(term_ctl), .pwr_mode(pwr_mode),
      .term_on(term_on_r), .leg_sel(leg_sel_r), .term_viol(term_viol_r)
   );

   localparam string REQ [0:10] = '{"R0", "R1", "R2", "R3", "R4", "R5",
                                    "R6", "R7", "R8", "R9", "R10"};

   // {req[3:0], wr, sel[1:0], ctl, mode[2:0], exp_on, exp_leg[2:0], exp_viol}
   localparam int NV = 46;
   localparam logic [15:0] VEC [0:NV-1] = '{
      16'b0101_0_00_1_000_0_000_0, // R5 init, no write
      16'b0101_0_00_1_001_0_000_0, // R5 active, still unwritten
      16'b0110_1_01_0_000_0_000_0, // R6 write 75 ohm
      16'b0110_0_01_1_001_0_000_1, // R6 first window cycle
      16'b0110_0_00_0_001_0_000_0,
      16'b0110_0_00_0_001_0_000_0,
      16'b0110_0_00_0_001_0_000_0,
      16'b0110_0_00_0_001_0_000_0,
      16'b0110_0_00_0_001_0_000_0,
      16'b0110_0_00_0_001_0_000_0,
      16'b0110_0_00_1_001_0_000_1, // R6 last window cycle
      16'b0011_0_00_1_001_1_001_0, // R3 active
      16'b0011_0_00_1_010_1_001_0, // R3 APD fast
      16'b0011_0_00_1_011_1_001_0, // R3 APD slow
      16'b0011_0_00_1_100_1_001_0, // R3 PPD
      16'b0100_0_00_1_101_0_000_1, // R4 self refresh entry
      16'b0100_0_00_0_101_0_000_0, // R4
      16'b0011_0_00_1_000_0_000_0, // R3 init mode gates off
      16'b0011_0_00_0_001_0_000_0,
      16'b0010_1_10_0_001_0_000_0, // R2 write 150 ohm
      16'b0110_0_00_0_001_0_000_0,
      16'b0110_0_00_0_001_0_000_0,
      16'b0110_0_00_0_001_0_000_0,
      16'b0110_0_00_0_001_0_000_0,
      16'b0110_0_00_0_001_0_000_0,
      16'b0110_0_00_0_001_0_000_0,
      16'b0110_0_00_0_001_0_000_0,
      16'b0110_0_00_0_001_0_000_0,
      16'b0010_0_00_1_001_1_010_0, // R2 150 ohm leg
      16'b0111_1_11_1_001_0_000_1, // R7 write cycle blocked
      16'b0111_0_00_0_001_0_000_0,
      16'b0111_0_00_0_001_0_000_0,
      16'b0111_0_00_0_001_0_000_0,
      16'b0111_0_00_0_001_0_000_0,
      16'b0111_1_11_0_001_0_000_0, // R7 restart
      16'b0111_0_00_0_001_0_000_0,
      16'b0111_0_00_0_001_0_000_0,
      16'b0111_0_00_0_001_0_000_0,
      16'b0111_0_00_0_001_0_000_0,
      16'b0111_0_00_0_001_0_000_0,
      16'b0111_0_00_0_001_0_000_0,
      16'b0111_0_00_0_001_0_000_0,
      16'b0111_0_00_1_001_0_000_1, // R7 still inside restarted window
      16'b0010_0_00_1_001_1_100_0, // R2 50 ohm leg
      16'b1010_1_00_1_001_0_000_0, // R10 disabling write
      16'b1010_0_00_1_001_0_000_0  // R10 stays off, no flag
   };

   task automatic check(input string tag, input logic [4:0] act, input logic [4:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s {on,leg,viol} actual=%b expected=%b", tag, act, exp);
      end
   endtask

   task automatic drive(input logic wr, input logic [1:0] sel, input logic ctl,
                        input logic [2:0] mode);
      emr_wr = wr; emr_sel = sel; term_ctl = ctl; pwr_mode = mode;
      @(negedge clk);
   endtask

   initial begin
      #(8 * 200000);
      n_bad++; n_chk++;
      $display("FAIL watchdog R1 actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      // R1 reset state
      term_ctl = 1'b1; pwr_mode = 3'd1;
      @(negedge clk); @(negedge clk);
      check("R1 reset", {term_on, leg_sel, term_viol}, 5'b0);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         drive(VEC[i][11], VEC[i][10:9], VEC[i][8], VEC[i][7:5]);
         check($sformatf("%s row %0d", REQ[VEC[i][15:12]], i),
               {term_on, leg_sel, term_viol}, VEC[i][4:0]);
      end

      // R8 reserved code with EN_50=0
      drive(1'b1, 2'b11, 1'b0, 3'd1);
      check("R8 reserved write flag", {term_on_r, leg_sel_r, term_viol_r}, 5'b0_000_1);
      check("R2 full variant no flag", {term_on, leg_sel, term_viol}, 5'b0);
      for (int k = 0; k < 8; k++) drive(1'b0, 2'b00, 1'b0, 3'd1);
      drive(1'b0, 2'b00, 1'b1, 3'd1);
      check("R8 reserved stored disabled", {term_on_r, leg_sel_r, term_viol_r}, 5'b0);
      check("R2 full variant 50 ohm", {term_on, leg_sel, term_viol}, 5'b1_100_0);

      // R1 reset mid-operation
      rst_n = 1'b0;
      drive(1'b0, 2'b00, 1'b1, 3'd1);
      check("R1 reset clears outputs", {term_on, leg_sel, term_viol}, 5'b0);
      rst_n = 1'b1;
      drive(1'b0, 2'b00, 1'b1, 3'd1);
      check("R1 select cleared", {term_on, leg_sel, term_viol}, 5'b0);

      // R10 enable then disable inside window: no holdoff left
      drive(1'b1, 2'b01, 1'b0, 3'd1);
      drive(1'b1, 2'b00, 1'b0, 3'd1);
      drive(1'b0, 2'b00, 1'b1, 3'd1);
      check("R10 no window after disable", {term_on, leg_sel, term_viol}, 5'b0);

      // R6 boundary: exactly HOLD_CYC quiet cycles then free
      drive(1'b1, 2'b01, 1'b0, 3'd4);
      for (int k = 0; k < 8; k++) drive(1'b0, 2'b00, 1'b0, 3'd4);
      drive(1'b0, 2'b00, 1'b1, 3'd4);
      check("R6 first free cycle", {term_on, leg_sel, term_viol}, 5'b1_001_0);

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule